// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. An active-low start strobe goes through a two-flop synchronizer. The block then alternates between an acquisition phase and a conversion phase, and it raises `busy` for the whole conversion. When the conversion ends it captures a result word from a digitizer input port. It holds that word and presents it on a shared parallel output bus that can be tri-stated.

Conversions can be triggered externally, with one falling edge of the strobe each. They can also retrigger themselves: while the strobe is held low, the block times its own acquisition and starts the next conversion when that acquisition is complete. A running conversion always completes, even if another strobe edge or a power-down request arrives. Power-down is applied only between conversions. A falling edge that arrives before the acquisition time has elapsed produces a one-cycle error pulse. The output word is given in straight offset binary or in twos complement, and the coding select can be changed at any time.

Top module: `sar_conv_seq`

## Requirements
- R1: A falling edge on `start_n` starts a conversion when acquisition is complete and the block is not asleep. `busy` rises on the third rising clock edge after `start_n` goes low, because of the two synchronizer flops.
- R2: `busy` stays high for exactly `CONV_CYC` clock cycles. Further edges on `start_n` during a conversion neither restart it nor shorten it.
- R3: Raising `pwr_dn` during a conversion does not abort it. `asleep` rises only while `busy` is low. While `asleep` is high, no conversion starts. After `pwr_dn` is released with `start_n` low, `busy` rises on the third edge.
- R4: While `start_n` is held low, `busy` stays low for exactly `ACQ_CYC+1` cycles between conversions, and the block retriggers with no further edge.
- R5: After reset, no conversion starts while `start_n` stays high.
- R6: The bus is driven, with `bus_en`=1, only when `sel_n`, `rden_n` and `ser_sel` are all 0. In every other case `data_bus` is high impedance and `bus_en` is 0.
- R7: With `twos_sel`=0 the bus carries the stored result unchanged. With `twos_sel`=1 the bus carries the stored result with bit 15 (the MSB) inverted.
- R8: The result is captured from `dig_data` on the clock edge where `busy` falls. Until that edge, the bus keeps showing the previous result.
- R9: A falling edge of `start_n` that arrives before `ACQ_CYC` acquisition cycles have elapsed pulses `early_err` for one cycle and does not start a conversion at that point. If `start_n` is still low, the conversion starts as soon as acquisition completes.
- R10: After reset, `busy`, `early_err` and `asleep` are 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low conversion start strobe (asynchronous) |
| pwr_dn | input | 1 | Power-down request |
| sel_n | input | 1 | Active-low chip select |
| rden_n | input | 1 | Active-low read enable |
| ser_sel | input | 1 | 1 selects serial mode and disables the parallel bus |
| twos_sel | input | 1 | 1 selects twos-complement output coding |
| dig_data | input | RES_W | Result word from the digitizer stub |
| busy | output | 1 | High while a conversion runs |
| early_err | output | 1 | One-cycle pulse on a premature start edge |
| asleep | output | 1 | Power-down is in effect |
| bus_en | output | 1 | The parallel bus is being driven |
| data_bus | output | RES_W | Tri-state result bus |

## Verification
The hardest states to reach from the ports are those where two events overlap: a power-down request that arrives in the middle of a conversion, and a strobe edge that falls inside the acquisition window. Directed sequences count clock edges from each fall of `busy` and drive `start_n` and `pwr_dn` at chosen offsets into the acquisition or conversion phase. A constrained-random phase then keeps the converter retriggering itself while it randomizes the bus enables, the serial select and the coding. A monitor checks the bus in every cycle against the last word the bench presented on `dig_data` at a fall of `busy`.

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_W    = 16,
  parameter int ACQ_CYC  = 8,
  parameter int CONV_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             pwr_dn,
  input  logic             sel_n,
  input  logic             rden_n,
  input  logic             ser_sel,
  input  logic             twos_sel,
  input  logic [RES_W-1:0] dig_data,
  output logic             busy,
  output logic             early_err,
  output logic             asleep,
  output logic             bus_en,
  output logic [RES_W-1:0] data_bus
);
  localparam int AW = $clog2(ACQ_CYC + 1);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic [2:0]       strb_sr;
  logic             pd_q;
  logic [AW-1:0]    acq_cnt;
  logic [CW-1:0]    conv_cnt;
  logic [RES_W-1:0] res_q;

  wire strb_low  = ~strb_sr[1];
  wire strb_fall = strb_sr[2] & ~strb_sr[1];
  wire acq_done  = acq_cnt == AW'(ACQ_CYC);
  wire conv_last = conv_cnt == CW'(CONV_CYC - 1);
  wire go        = ~busy & ~asleep & strb_low & acq_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_sr <= 3'b111;
      pd_q    <= 1'b0;
    end else begin
      strb_sr <= {strb_sr[1:0], start_n};
      pd_q    <= pwr_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      conv_cnt <= '0;
      acq_cnt  <= AW'(ACQ_CYC);
      res_q    <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      conv_cnt <= '0;
    end else if (busy) begin
      if (conv_last) begin
        busy    <= 1'b0;
        res_q   <= dig_data;
        acq_cnt <= '0;
      end else begin
        conv_cnt <= conv_cnt + 1'b1;
      end
    end else if (!acq_done) begin
      acq_cnt <= acq_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_err <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      early_err <= ~busy & strb_fall & ~acq_done;
      if (!pd_q)
        asleep <= 1'b0;
      else if (!busy && !go)
        asleep <= 1'b1;
    end
  end

  wire [RES_W-1:0] coded = {res_q[RES_W-1] ^ twos_sel, res_q[RES_W-2:0]};

  assign bus_en   = ~(sel_n | rden_n | ser_sel);
  assign data_bus = bus_en ? coded : 'z;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int RES_W    = 16,
  parameter int ACQ_CYC  = 8,
  parameter int CONV_CYC = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             twos_sel,
  input logic             busy,
  input logic             early_err,
  input logic             asleep,
  input logic             bus_en,
  input logic [RES_W-1:0] data_bus
);
  localparam int CW = $clog2(CONV_CYC + 2);
  localparam int IW = $clog2(ACQ_CYC + 2);

  logic [CW-1:0] busy_len;
  logic [IW-1:0] idle_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
      idle_len <= IW'(ACQ_CYC);
    end else begin
      busy_len <= busy ? busy_len + 1'b1 : '0;
      if (busy)
        idle_len <= '0;
      else if (idle_len != IW'(ACQ_CYC + 1))
        idle_len <= idle_len + 1'b1;
    end
  end

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> busy_len == CW'(CONV_CYC)); // R2
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> busy_len < CW'(CONV_CYC)); // R2
  AST_ACQ_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> idle_len == IW'(ACQ_CYC + 1)); // R4
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !$past(asleep)); // R3
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(asleep) |-> !busy); // R3
  AST_EARLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) early_err |-> !busy); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && bus_en && $past(bus_en) && $stable(twos_sel)) |-> $stable(data_bus)); // R8
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .twos_sel(twos_sel), .busy(busy), .early_err(early_err),
  .asleep(asleep), .bus_en(bus_en), .data_bus(data_bus));

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
  localparam int RES_W = 16, ACQ_CYC = 8, CONV_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0, start_n = 1'b1, pwr_dn = 1'b0;
  logic sel_n = 1'b0, rden_n = 1'b0, ser_sel = 1'b0, twos_sel = 1'b0;
  logic [RES_W-1:0] dig_data = '0;
  logic busy, early_err, asleep, bus_en;
  logic [RES_W-1:0] data_bus;

  int n_chk = 0, n_bad = 0;
  bit run = 0, done = 0, prev_busy = 0;
  logic [RES_W-1:0] exp_res = '0;

  always #5 clk = ~clk;

  sar_conv_seq #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwr_dn(pwr_dn), .sel_n(sel_n),
    .rden_n(rden_n), .ser_sel(ser_sel), .twos_sel(twos_sel), .dig_data(dig_data),
    .busy(busy), .early_err(early_err), .asleep(asleep), .bus_en(bus_en), .data_bus(data_bus));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] code(input logic [RES_W-1:0] r, input logic t);
    return {r[RES_W-1] ^ t, r[RES_W-2:0]};
  endfunction

  always @(negedge clk) begin
    if (run) begin
      if (prev_busy && !busy) exp_res = dig_data;
      prev_busy = busy;
      chk(bus_en == (!sel_n && !rden_n && !ser_sel), "R6 bus enable", {31'd0, bus_en}, {31'd0, !sel_n && !rden_n && !ser_sel});
      if (!sel_n && !rden_n && !ser_sel)
        chk(data_bus == code(exp_res, twos_sel), twos_sel ? "R7 twos coding" : "R8 result word", {16'd0, data_bus}, {16'd0, code(exp_res, twos_sel)});
      dig_data = RES_W'($urandom);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_lvl(input logic lvl, output int n);
    n = 0;
    do begin step(1); n++; end while (busy !== lvl && n < 200);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n, m, seen;
    void'($urandom(32'd4711));
    step(5);
    rst_n = 1'b1;
    step(1);
    run = 1;
    chk(busy == 0 && early_err == 0 && asleep == 0, "R10 flags after reset", {29'd0, busy, early_err, asleep}, 0);
    chk(data_bus == 0, "R10 result after reset", {16'd0, data_bus}, 0);

    seen = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (busy) seen = 1; end
    chk(seen == 0, "R5 no conversion while strobe high", seen, 0);

    start_n = 1'b0;
    wait_lvl(1'b1, n);
    chk(n == 3, "R1 start latency", n, 3);
    step(2); start_n = 1'b1; step(3); start_n = 1'b0; step(1); start_n = 1'b1;
    wait_lvl(1'b0, m);
    chk(6 + m == CONV_CYC, "R2 conversion length with restart attempt", 6 + m, CONV_CYC);

    step(2); start_n = 1'b0;
    seen = 0;
    for (int i = 0; i < 5; i++) begin step(1); if (early_err) seen = 1; end
    chk(seen == 1, "R9 early edge flagged", seen, 1);
    wait_lvl(1'b1, n);
    chk(7 + n == ACQ_CYC + 1, "R9 start after acquisition completes", 7 + n, ACQ_CYC + 1);

    for (int k = 0; k < 2; k++) begin
      wait_lvl(1'b0, m);
      chk(m == CONV_CYC, "R2 self-retriggered conversion length", m, CONV_CYC);
      wait_lvl(1'b1, n);
      chk(n == ACQ_CYC + 1, "R4 retrigger gap", n, ACQ_CYC + 1);
    end

    pwr_dn = 1'b1;
    wait_lvl(1'b0, m);
    chk(m == CONV_CYC, "R3 power-down does not abort", m, CONV_CYC);
    step(3);
    chk(asleep == 1 && busy == 0, "R3 asleep after conversion", {30'd0, asleep, busy}, 2);
    seen = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (busy) seen = 1; end
    chk(seen == 0, "R3 no conversion while asleep", seen, 0);
    pwr_dn = 1'b0;
    wait_lvl(1'b1, n);
    chk(n == 3, "R3 resume after release", n, 3);

    start_n = 1'b1;
    wait_lvl(1'b0, m);
    step(ACQ_CYC + 4);
    start_n = 1'b0;
    seen = 0;
    n = 0;
    do begin step(1); n++; if (early_err) seen = 1; end while (!busy && n < 200);
    chk(n == 3, "R1 clean edge latency", n, 3);
    chk(seen == 0, "R9 no flag on timely edge", seen, 0);

    for (int i = 0; i < 600; i++) begin
      step(1);
      sel_n    = ($urandom % 4) == 0;
      rden_n   = ($urandom % 4) == 0;
      ser_sel  = ($urandom % 6) == 0;
      twos_sel = $urandom % 2;
    end
    sel_n = 0; rden_n = 0; ser_sel = 0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (($urandom % 8) == 0) start_n = ~start_n;
      twos_sel = $urandom % 2;
    end
    step(2);
    finish_run();
  end
endmodule